// File: doc/BRIEF.md
# PLL Control and Lock-Status Register

This block is the memory-mapped control word of a phase-locked loop inside a clock generation unit. Software programs three ratio fields through it: a feedback multiplier, an input (reference) divider and an output divider. It also sets an enable and a bypass control. The block stores each ratio field minus a fixed offset, which keeps the field narrow. It decodes the fields into the effective multiply and divide ratios, which a downstream clock model uses directly.

The analog loop is not modelled. Lock acquisition is represented by a counter of reference-domain ticks. When the loop is enabled, or its ratio changes while it runs, the counter restarts. When the counter expires, a read-only stable flag rises. Software sets enable and then polls the stable flag before it relies on the output clock. The output divider uses a sparse 2-bit code. One of its codes is illegal. A write that carries the illegal code keeps the previous divider and sets a sticky error flag, which is held in a second status word.

The bus is a plain single-cycle register port with a word address, a write strobe, write data and combinational read data. The control word and the status word each sit at a parameterised word address.

Top module: `pll_ctl_reg`

## Requirements
- R1: In the control word, the multiplier field occupies bits 31:23 and the input divider field occupies bits 22:18. Both fields read back exactly as they were written.
- R2: The multiplier output equals the stored multiplier plus 2, and the input divider output equals the stored input divider plus 2. Both apply from the cycle after the write.
- R3: The output divider field occupies bits 17:16. Codes 0, 1 and 3 give divide-by-1, divide-by-2 and divide-by-4 on the output divider output.
- R4: A control write that carries output divider code 2 leaves the stored code unchanged and still writes every other field. It also sets bit 0 of the status word. That bit stays 1 until a status write with bit 0 set, or a reset.
- R5: Bit 8 is enable and bit 10 is the stable flag. When enable goes from 0 to 1, stable reads 0 until LOCK_TICKS reference ticks have been counted. It reads 1 from the cycle after the tick that completes the count.
- R6: A write that clears enable clears stable in the same clock edge.
- R7: While enable is 1, a write that changes the multiplier, the input divider or the stored output divider restarts the lock count and clears stable. A write that keeps all three ratio fields unchanged leaves stable and the count untouched.
- R8: Bit 9 is bypass. While bypass is 1, all three ratio outputs read 1, whatever the other fields hold and whatever the lock state is.
- R9: Bits 15:11 and 7:0 of the control word read as 0. Writes to those bits, and to the stable bit 10, have no effect.
- R10: Reads from any other word address return 0. Writes to any other word address change no state.
- R11: After reset, both words read 0, and the ratio outputs are multiplier 2, input divider 2 and output divider 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle pulse per reference-clock period, used to count lock time |
| bus_addr | input | ADDR_W | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word (combinational) |
| ratio_mult | output | 10 | Effective feedback multiplier |
| ratio_prediv | output | 6 | Effective input divider |
| ratio_postdiv | output | 3 | Effective output divider |

## Verification
The field decode is exercised with all-ones ratio fields that also carry junk in the reserved and stable bits, with all-zero fields, with small distinct values, with the illegal output-divider code, and with a single high bit in each field. Together these separate a wrong field position or offset from a missing reserved-bit mask, and a lost sticky error from a divider that was wrongly overwritten. The lock timing is tried with ticks spaced several clocks apart, which shows that the count runs on ticks and not on clocks. It is also tried with a same-value rewrite, with a real ratio change while stable, with a bypass change and with clearing enable. These cases separate a restart that fires too often from one that never fires.

// File: rtl/pll_ctl_pkg.sv
// Package: pll_ctl_pkg
// Field positions, offsets and shared types for the PLL control word.
// Assumes a 32-bit register bus; positions are fixed by the software view.
package pll_ctl_pkg;

    localparam int DATA_W     = 32;
    localparam int MULT_LSB   = 23;
    localparam int MULT_W     = 9;
    localparam int PRE_LSB    = 18;
    localparam int PRE_W      = 5;
    localparam int OD_LSB     = 16;
    localparam int OD_W       = 2;
    localparam int STABLE_BIT = 10;
    localparam int BYPASS_BIT = 9;
    localparam int ENABLE_BIT = 8;
    localparam int MULT_OFS   = 2;
    localparam int PRE_OFS    = 2;

    // Output widths: one extra bit absorbs the stored-value offset
    localparam int MULT_OUT_W = MULT_W + 1;
    localparam int PRE_OUT_W  = PRE_W + 1;
    localparam int POST_OUT_W = 3;

    typedef enum logic [OD_W-1:0] {
        OD_DIV1 = 2'd0,
        OD_DIV2 = 2'd1,
        OD_BAD  = 2'd2,
        OD_DIV4 = 2'd3
    } od_code_t;

    typedef struct packed {
        logic [MULT_W-1:0] mult;
        logic [PRE_W-1:0]  prediv;
        od_code_t          od;
        logic              bypass;
        logic              enable;
    } pll_fields_t;

    // Map a legal output divider code to its divide ratio
    function automatic logic [POST_OUT_W-1:0] od_ratio(input od_code_t code);
        case (code)
            OD_DIV2: od_ratio = 3'd2;
            OD_DIV4: od_ratio = 3'd4;
            default: od_ratio = 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/pll_wr_decode.sv
// Module: pll_wr_decode
// Computes the next field values for a control write, rejects the illegal
// output divider code, and flags a restart of lock acquisition.
// Assumes it is purely combinational; the caller registers the results.
module pll_wr_decode
    import pll_ctl_pkg::*;
(
    input  pll_fields_t       cur,
    input  logic              hit,
    input  logic [DATA_W-1:0] wdata,
    output pll_fields_t       nxt,
    output logic              bad_code,
    output logic              restart
);

    od_code_t    od_req;
    logic        ratio_moved;

    // Purpose: slice the write word into fields, keeping the old code on a bad one
    always_comb begin
        od_req   = od_code_t'(wdata[OD_LSB +: OD_W]);
        bad_code = hit && (od_req == OD_BAD);
        nxt      = cur;
        if (hit) begin
            nxt.mult   = wdata[MULT_LSB +: MULT_W];
            nxt.prediv = wdata[PRE_LSB +: PRE_W];
            nxt.bypass = wdata[BYPASS_BIT];
            nxt.enable = wdata[ENABLE_BIT];
            if (od_req != OD_BAD) begin
                nxt.od = od_req;
            end
        end
    end

    // Purpose: decide whether lock must be reacquired after this write
    always_comb begin
        ratio_moved = (nxt.mult != cur.mult) || (nxt.prediv != cur.prediv) ||
                      (nxt.od != cur.od);
        restart     = hit && nxt.enable && (!cur.enable || ratio_moved);
    end

endmodule

// File: rtl/pll_lock_timer.sv
// Module: pll_lock_timer
// Counts reference ticks after a restart and raises stable when the count
// completes. Assumes ref_tick is a one-cycle pulse in the clk domain and
// LOCK_TICKS >= 1.
module pll_lock_timer #(
    parameter int LOCK_TICKS = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_nxt,
    input  logic restart,
    input  logic ref_tick,
    output logic stable
);

    localparam int CNT_W = $clog2(LOCK_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_TICKS - 1);

    logic [CNT_W-1:0] cnt;

    // Purpose: run the lock counter and hold the stable flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            stable <= 1'b0;
        end else if (!en_nxt || restart) begin
            cnt    <= '0;
            stable <= 1'b0;
        end else if (ref_tick && !stable) begin
            if (cnt == LAST) begin
                stable <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R5: stable only rises on a counted tick
    p_rise_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stable) |-> $past(ref_tick));

    // R7: a restart leaves stable low on the next cycle
    p_restart_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !stable);

endmodule

// File: rtl/pll_ratio_out.sv
// Module: pll_ratio_out
// Turns stored fields into effective ratios for the downstream clock model,
// adding the field offsets and forcing 1:1 in bypass.
// Assumes the stored output divider code is never the illegal one.
module pll_ratio_out
    import pll_ctl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  pll_fields_t           fld,
    output logic [MULT_OUT_W-1:0] mult,
    output logic [PRE_OUT_W-1:0]  prediv,
    output logic [POST_OUT_W-1:0] postdiv
);

    // Purpose: add offsets, decode the divider, and apply bypass
    always_comb begin
        if (fld.bypass) begin
            mult    = MULT_OUT_W'(1);
            prediv  = PRE_OUT_W'(1);
            postdiv = POST_OUT_W'(1);
        end else begin
            mult    = MULT_OUT_W'(fld.mult) + MULT_OUT_W'(MULT_OFS);
            prediv  = PRE_OUT_W'(fld.prediv) + PRE_OUT_W'(PRE_OFS);
            postdiv = od_ratio(fld.od);
        end
    end

    // R8: bypass reports unity ratios
    p_bypass_unity_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fld.bypass |-> (mult == 1 && prediv == 1 && postdiv == 1));

    // R2: without bypass, ratios never fall below the offset
    p_offset_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !fld.bypass |-> (mult >= MULT_OUT_W'(MULT_OFS) && prediv >= PRE_OUT_W'(PRE_OFS)));

endmodule

// File: rtl/pll_ctl_reg.sv
// Module: pll_ctl_reg (top)
// PLL control word with lock status plus a status word holding a sticky
// illegal-code flag. Assumes single-cycle bus writes and combinational reads.
module pll_ctl_reg
    import pll_ctl_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int CTRL_ADDR  = 4,
    parameter int STAT_ADDR  = 5,
    parameter int LOCK_TICKS = 256
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ref_tick,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_we,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic [MULT_OUT_W-1:0] ratio_mult,
    output logic [PRE_OUT_W-1:0]  ratio_prediv,
    output logic [POST_OUT_W-1:0] ratio_postdiv
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

    pll_fields_t fld_q;
    pll_fields_t fld_nxt;
    logic        ctrl_hit;
    logic        stat_hit;
    logic        bad_code;
    logic        restart;
    logic        stable;
    logic        err_q;

    // Purpose: decode which word a write targets
    always_comb begin
        ctrl_hit = bus_we && (bus_addr == A_CTRL);
        stat_hit = bus_we && (bus_addr == A_STAT);
    end

    pll_wr_decode u_dec (
        .cur      (fld_q),
        .hit      (ctrl_hit),
        .wdata    (bus_wdata),
        .nxt      (fld_nxt),
        .bad_code (bad_code),
        .restart  (restart)
    );

    // Purpose: hold the writable control fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fld_q <= '{mult: '0, prediv: '0, od: OD_DIV1, bypass: 1'b0, enable: 1'b0};
        end else begin
            fld_q <= fld_nxt;
        end
    end

    // Purpose: keep the sticky illegal-code flag, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (bad_code) begin
            err_q <= 1'b1;
        end else if (stat_hit && bus_wdata[0]) begin
            err_q <= 1'b0;
        end
    end

    pll_lock_timer #(.LOCK_TICKS(LOCK_TICKS)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_nxt   (fld_nxt.enable),
        .restart  (restart),
        .ref_tick (ref_tick),
        .stable   (stable)
    );

    pll_ratio_out u_ratio (
        .clk     (clk),
        .rst_n   (rst_n),
        .fld     (fld_q),
        .mult    (ratio_mult),
        .prediv  (ratio_prediv),
        .postdiv (ratio_postdiv)
    );

    // Purpose: assemble read data; reserved bits and unmapped words read 0
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL) begin
            bus_rdata[MULT_LSB +: MULT_W] = fld_q.mult;
            bus_rdata[PRE_LSB +: PRE_W]   = fld_q.prediv;
            bus_rdata[OD_LSB +: OD_W]     = fld_q.od;
            bus_rdata[STABLE_BIT]         = stable;
            bus_rdata[BYPASS_BIT]         = fld_q.bypass;
            bus_rdata[ENABLE_BIT]         = fld_q.enable;
        end else if (bus_addr == A_STAT) begin
            bus_rdata[0] = err_q;
        end
    end

    // R3: the stored divider code is always a legal one
    p_od_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fld_q.od != OD_BAD);

    // R4: an illegal code leaves the divider unchanged and raises the error
    p_bad_code_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_hit && bus_wdata[OD_LSB +: OD_W] == 2'd2) |=> ($stable(fld_q.od) && err_q));

    // R4: the error flag holds until cleared
    p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !(stat_hit && bus_wdata[0])) |=> err_q);

    // R6: dropping enable drops stable at the same edge
    p_stable_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fld_q.enable) |-> !stable);

    // R5: stable is never seen while disabled
    p_stable_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stable |-> fld_q.enable);

endmodule

// File: tb/sim_pll_ctl_reg.sv
module sim_pll_ctl_reg;

    localparam int LOCK = 16;
    localparam logic [5:0] A_CTRL = 6'd4;
    localparam logic [5:0] A_STAT = 6'd5;
    localparam int NV = 5;

    // Vector table: write word, expected readback, mult, prediv, postdiv, error flag
    localparam logic [31:0] V_WR  [NV] = '{32'hFFFF_FCFF, 32'h0000_0000, 32'h0089_0000,
                                            32'h028E_0000, 32'h8043_0000};
    localparam logic [31:0] V_RD  [NV] = '{32'hFFFF_0000, 32'h0000_0000, 32'h0089_0000,
                                            32'h028D_0000, 32'h8043_0000};
    localparam int          V_MUL [NV] = '{513, 2, 3, 7, 258};
    localparam int          V_PRE [NV] = '{33, 2, 4, 5, 18};
    localparam int          V_PST [NV] = '{4, 1, 2, 2, 4};
    localparam int          V_ERR [NV] = '{0, 0, 0, 1, 1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [9:0]  ratio_mult;
    logic [5:0]  ratio_prediv;
    logic [2:0]  ratio_postdiv;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    pll_ctl_reg #(.ADDR_W(6), .CTRL_ADDR(4), .STAT_ADDR(5), .LOCK_TICKS(LOCK)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ratio_mult(ratio_mult), .ratio_prediv(ratio_prediv), .ratio_postdiv(ratio_postdiv)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ref_tick = 1'b1;
            @(negedge clk); ref_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic check_ratios(input string req, input int m, input int p, input int o);
        #1;
        check(req, 32'(ratio_mult), 32'(m));
        check(req, 32'(ratio_prediv), 32'(p));
        check(req, 32'(ratio_postdiv), 32'(o));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [31:0] fields;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        rd(A_CTRL, r); check("R11 ctrl reset", r, 32'h0);
        rd(A_STAT, r); check("R11 stat reset", r, 32'h0);
        check_ratios("R11 reset ratios", 2, 2, 1);

        // R1 R2 R3 R4 R9: vector table walk
        for (int i = 0; i < NV; i++) begin
            wr(A_CTRL, V_WR[i]);
            rd(A_CTRL, r); check("R1 R3 R9 readback", r, V_RD[i]);
            check_ratios("R2 R3 ratios", V_MUL[i], V_PRE[i], V_PST[i]);
            rd(A_STAT, r); check("R4 error flag", r, 32'(V_ERR[i]));
        end

        // R4: clearing the sticky flag
        wr(A_STAT, 32'h0); rd(A_STAT, r); check("R4 zero write keeps err", r, 32'h1);
        wr(A_STAT, 32'h1); rd(A_STAT, r); check("R4 clear err", r, 32'h0);

        // R10: unmapped address
        wr(6'd7, 32'hFFFF_FFFF);
        rd(6'd7, r); check("R10 unmapped read", r, 32'h0);
        rd(A_CTRL, r); check("R10 ctrl untouched", r, 32'h8043_0000);
        rd(A_STAT, r); check("R10 stat untouched", r, 32'h0);

        // R9: stable bit not writable while disabled
        wr(A_CTRL, 32'h0000_0400);
        rd(A_CTRL, r); check("R9 stable write ignored", r, 32'h0);

        // R5: lock acquisition counts ticks
        fields = 32'h0089_0000;
        wr(A_CTRL, fields | 32'h100);
        repeat (20) @(negedge clk);
        rd(A_CTRL, r); check("R5 no ticks no lock", r, fields | 32'h100);
        ticks(LOCK - 1);
        rd(A_CTRL, r); check("R5 one tick short", r, fields | 32'h100);
        ticks(1);
        rd(A_CTRL, r); check("R5 locked", r, fields | 32'h500);

        // R7: same-value rewrite keeps lock
        wr(A_CTRL, fields | 32'h100);
        rd(A_CTRL, r); check("R7 same write keeps lock", r, fields | 32'h500);

        // R7: changing the multiplier restarts the count
        fields = 32'h0109_0000;
        wr(A_CTRL, fields | 32'h100);
        rd(A_CTRL, r); check("R7 change clears stable", r, fields | 32'h100);
        ticks(LOCK - 1);
        rd(A_CTRL, r); check("R7 relock not yet", r, fields | 32'h100);
        ticks(1);
        rd(A_CTRL, r); check("R7 relocked", r, fields | 32'h500);

        // R8: bypass forces unity and does not disturb lock
        wr(A_CTRL, fields | 32'h300);
        check_ratios("R8 bypass unity", 1, 1, 1);
        rd(A_CTRL, r); check("R8 bypass keeps lock", r, fields | 32'h700);
        wr(A_CTRL, fields | 32'h100);
        check_ratios("R8 bypass off", 4, 4, 2);

        // R6: clearing enable drops stable at once
        wr(A_CTRL, fields);
        rd(A_CTRL, r); check("R6 disable clears stable", r, fields);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule